// File: doc/BRIEF.md
# MESI Snoop Response Unit

This unit is the bus-facing snoop agent of one cache. Other agents broadcast coherence requests on a shared bus: a plain read, an invalidate, or a read that also invalidates. The unit looks the address up in its own direct-mapped tag and state store. It then downgrades or invalidates the local copy and returns the reply the requester needs. That reply is either a data response carrying the whole cache line or an acknowledgement that the requester counts. A dirty line that must remain readable by others is first written back to memory on a simple write port, and only then is the data response sent.

Only one snoop is handled at a time. While a write-back or a reply is outstanding, the request channel is held not-ready. Each reply is held on its port until the requester takes it with a ready handshake. The reply carries the requester's identifier and the snooped address, so the requester can match it. The local cache controller installs and changes lines through a fill port. That port stands in for the local request path, which sits outside this block.

Top module: `mesi_snoop_unit`

## Requirements
- R1: After reset every set holds state Invalid, `snp_ready` is 1, and `rsp_valid` and `wb_valid` are 0.
- R2: A read (`snp_op`=0) that hits a line in Shared or Exclusive state produces exactly one reply with `rsp_kind`=0. The reply carries the full stored line in `rsp_data`, `rsp_dst` equal to the snooped source and `rsp_addr` equal to the snooped address. The line state becomes Shared.
- R3: A read that hits a Modified line first raises `wb_valid` with the line-aligned address and the line data. Only after that write-back is accepted does the R2 data reply appear. The line then leaves Modified, so a repeated read causes no further write-back.
- R4: A read that misses produces no write-back and no reply, and `snp_ready` is 1 in the following cycle. A miss means the state is Invalid or the tag differs; main memory supplies the data in that case.
- R5: An invalidate (`snp_op`=1) always produces exactly one reply with `rsp_kind`=1 and `rsp_data` zero, whether it hits or misses. On a hit the line becomes Invalid.
- R6: A read-invalidate (`snp_op`=2) that hits any valid line produces a data reply and then an acknowledgement, with no write-back even when the line was Modified. The line becomes Invalid.
- R7: A read-invalidate that misses produces only the acknowledgement.
- R8: A request whose `snp_src` equals the parameter `MY_ID`, or whose `snp_op` is 3, is accepted and dropped. It leaves no reply, no write-back and no state change.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the reply fields stay unchanged. The same holds for the write-back fields while `wb_valid` is 1 and `wb_ready` is 0.
- R10: Addresses split into a byte offset (low log2(LINE_W/8) bits), a set index (next log2(SETS) bits) and a tag (remaining bits). Two addresses with the same index but different tags do not hit each other.
- R11: With `fill_en` at 1, the set selected by `fill_line` (the address without its offset) takes the tag, data and state from the fill port in the next cycle. The state encoding is 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified.
- R12: `snp_ready` is 0 from the cycle after a request that needs a reply is accepted until its last reply is taken. No reply or write-back appears unless a snoop asked for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_valid | input | 1 | Snooped request present |
| snp_ready | output | 1 | Unit can take a snooped request |
| snp_op | input | 2 | 0 read, 1 invalidate, 2 read-invalidate, 3 none |
| snp_src | input | ID_W | Identifier of the requesting agent |
| snp_addr | input | ADDR_W | Byte address of the request |
| fill_en | input | 1 | Local install of a line |
| fill_line | input | ADDR_W-OFF_W | Line address to install |
| fill_st | input | 2 | State to install |
| fill_data | input | LINE_W | Line contents to install |
| wb_valid | output | 1 | Write-back to memory pending |
| wb_ready | input | 1 | Memory takes the write-back |
| wb_addr | output | ADDR_W | Line-aligned write-back address |
| wb_data | output | LINE_W | Line written back |
| rsp_valid | output | 1 | Reply pending |
| rsp_ready | input | 1 | Requester takes the reply |
| rsp_kind | output | 1 | 0 data reply, 1 invalidate acknowledgement |
| rsp_dst | output | ID_W | Requester the reply is for |
| rsp_addr | output | ADDR_W | Snooped address echoed |
| rsp_data | output | LINE_W | Line contents, zero in an acknowledgement |

## Verification
The bound checker watches several rules on every cycle. Replies and write-backs hold steady under back-pressure, and a write-back never overlaps a reply. An accepted write-back is followed at once by a data reply, and every foreign invalidate is answered with an acknowledgement in the next cycle. Requests from the unit's own identifier and read-invalidates never start a write-back, and the request channel stays closed while a reply is pending. The line contents, the tag decode and the lasting state changes (Modified dropping to Shared, hits turning Invalid, misses leaving lines alone) show up only over later snoops. The bench's reference model and its scenario sequences cover those.

// File: rtl/mesi_snp_pkg.sv
package mesi_snp_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_INV   = 2'd1,
        OP_RDINV = 2'd2,
        OP_NONE  = 2'd3
    } snp_op_t;

    typedef enum logic {
        RK_DATA = 1'b0,
        RK_ACK  = 1'b1
    } rsp_kind_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WB   = 2'd1,
        SQ_DATA = 2'd2,
        SQ_ACK  = 2'd3
    } seq_t;

    // What one accepted snoop has to do
    typedef struct packed {
        logic  go_wb;    // write dirty line to memory first
        logic  go_data;  // send a data reply
        logic  go_ack;   // send an invalidate acknowledgement
        logic  upd;      // change local state
        mesi_t nxt;      // state to change to
    } plan_t;

    function automatic plan_t snoop_plan(snp_op_t op, logic hit, mesi_t st);
        plan_t p;
        p = '0;
        p.nxt = ST_I;
        case (op)
            OP_READ: begin
                if (hit) begin
                    p.go_data = 1'b1;
                    p.go_wb   = (st == ST_M);
                    p.upd     = 1'b1;
                    p.nxt     = ST_S;
                end
            end
            OP_INV: begin
                p.go_ack = 1'b1;
                p.upd    = hit;
            end
            OP_RDINV: begin
                p.go_ack  = 1'b1;
                p.go_data = hit;
                p.upd     = hit;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/snp_line_store.sv
module snp_line_store
    import mesi_snp_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int TAG_W  = 10,
    parameter int LINE_W = 64,
    parameter int IDX_W  = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    output mesi_t             lk_st,
    output logic [LINE_W-1:0] lk_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  mesi_t             fill_st,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  mesi_t             upd_st
);

    logic [TAG_W-1:0]  tag_q  [SETS];
    mesi_t             st_q   [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (rst) begin
                st_q[s] <= ST_I;
            end else if (upd_en && upd_idx == IDX_W'(s)) begin
                st_q[s] <= upd_st;   // snoop outcome wins a same-set clash
            end else if (fill_en && fill_idx == IDX_W'(s)) begin
                st_q[s] <= fill_st;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (fill_en && fill_idx == IDX_W'(s)) begin
                tag_q[s]  <= fill_tag;
                data_q[s] <= fill_data;
            end
        end
    end

    assign lk_tag  = tag_q[lk_idx];
    assign lk_st   = st_q[lk_idx];
    assign lk_data = data_q[lk_idx];

endmodule

// File: rtl/snp_seq.sv
module snp_seq
    import mesi_snp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 64,
    parameter int ID_W   = 2,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  plan_t             plan,
    input  logic [ID_W-1:0]   req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] line_data,
    output logic              idle,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LINE_W-1:0] wb_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_kind,
    output logic [ID_W-1:0]   rsp_dst,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LINE_W-1:0] rsp_data
);

    seq_t              state_q;
    logic              ack_q;
    logic [ID_W-1:0]   src_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LINE_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            ack_q   <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (take) begin
                        ack_q <= plan.go_ack;
                        if (plan.go_wb)        state_q <= SQ_WB;
                        else if (plan.go_data) state_q <= SQ_DATA;
                        else if (plan.go_ack)  state_q <= SQ_ACK;
                    end
                end
                SQ_WB:   if (wb_ready)  state_q <= SQ_DATA;
                SQ_DATA: if (rsp_ready) state_q <= ack_q ? SQ_ACK : SQ_IDLE;
                default: if (rsp_ready) state_q <= SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == SQ_IDLE && take) begin
            src_q  <= req_src;
            addr_q <= req_addr;
            data_q <= line_data;
        end
    end

    assign idle      = (state_q == SQ_IDLE);
    assign wb_valid  = (state_q == SQ_WB);
    assign wb_addr   = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign wb_data   = data_q;
    assign rsp_valid = (state_q == SQ_DATA) || (state_q == SQ_ACK);
    assign rsp_kind  = (state_q == SQ_ACK) ? RK_ACK : RK_DATA;
    assign rsp_dst   = src_q;
    assign rsp_addr  = addr_q;
    assign rsp_data  = (state_q == SQ_ACK) ? '0 : data_q;

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_snp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 64,
    parameter int SETS   = 8,
    parameter int ID_W   = 2,
    parameter logic [ID_W-1:0] MY_ID = 1,
    localparam int OFF_W = $clog2(LINE_W / 8),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    snp_valid,
    output logic                    snp_ready,
    input  logic [1:0]              snp_op,
    input  logic [ID_W-1:0]         snp_src,
    input  logic [ADDR_W-1:0]       snp_addr,
    input  logic                    fill_en,
    input  logic [ADDR_W-OFF_W-1:0] fill_line,
    input  logic [1:0]              fill_st,
    input  logic [LINE_W-1:0]       fill_data,
    output logic                    wb_valid,
    input  logic                    wb_ready,
    output logic [ADDR_W-1:0]       wb_addr,
    output logic [LINE_W-1:0]       wb_data,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic                    rsp_kind,
    output logic [ID_W-1:0]         rsp_dst,
    output logic [ADDR_W-1:0]       rsp_addr,
    output logic [LINE_W-1:0]       rsp_data
);

    logic              idle;
    logic              take;
    logic              hit;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    logic [TAG_W-1:0]  lk_tag;
    mesi_t             lk_st;
    logic [LINE_W-1:0] lk_data;
    plan_t             plan;

    assign snp_idx   = snp_addr[OFF_W +: IDX_W];
    assign snp_tag   = snp_addr[ADDR_W-1 -: TAG_W];
    assign hit       = (lk_st != ST_I) && (lk_tag == snp_tag);
    assign take      = snp_valid && idle && (snp_src != MY_ID);
    assign plan      = snoop_plan(snp_op_t'(snp_op), hit, lk_st);
    assign snp_ready = idle;

    snp_line_store #(
        .SETS   (SETS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (snp_idx),
        .lk_tag    (lk_tag),
        .lk_st     (lk_st),
        .lk_data   (lk_data),
        .fill_en   (fill_en),
        .fill_idx  (fill_line[IDX_W-1:0]),
        .fill_tag  (fill_line[ADDR_W-OFF_W-1 -: TAG_W]),
        .fill_st   (mesi_t'(fill_st)),
        .fill_data (fill_data),
        .upd_en    (take && plan.upd),
        .upd_idx   (snp_idx),
        .upd_st    (plan.nxt)
    );

    snp_seq #(
        .ADDR_W (ADDR_W),
        .LINE_W (LINE_W),
        .ID_W   (ID_W),
        .OFF_W  (OFF_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .plan      (plan),
        .req_src   (snp_src),
        .req_addr  (snp_addr),
        .line_data (lk_data),
        .idle      (idle),
        .wb_valid  (wb_valid),
        .wb_ready  (wb_ready),
        .wb_addr   (wb_addr),
        .wb_data   (wb_data),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_kind  (rsp_kind),
        .rsp_dst   (rsp_dst),
        .rsp_addr  (rsp_addr),
        .rsp_data  (rsp_data)
    );

endmodule

// File: rtl/snp_checker.sv
module snp_checker #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 64,
    parameter int ID_W   = 2,
    parameter logic [ID_W-1:0] MY_ID = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              snp_valid,
    input logic              snp_ready,
    input logic [1:0]        snp_op,
    input logic [ID_W-1:0]   snp_src,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              wb_valid,
    input logic              wb_ready,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [LINE_W-1:0] wb_data,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_kind,
    input logic [ID_W-1:0]   rsp_dst,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic [LINE_W-1:0] rsp_data
);

    logic foreign;
    assign foreign = snp_valid && snp_ready && (snp_src != MY_ID);

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_dst)
            && $stable(rsp_addr) && $stable(rsp_data)); // R9

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data)); // R9

    AST_WB_ALONE: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> !rsp_valid && !snp_ready); // R3

    AST_WB_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
        wb_valid && wb_ready |=> rsp_valid && (rsp_kind == 1'b0)); // R3

    AST_INV_ACKED: assert property (@(posedge clk) disable iff (rst)
        foreign && (snp_op == 2'd1) |=> rsp_valid && (rsp_kind == 1'b1)
            && (rsp_dst == $past(snp_src)) && (rsp_addr == $past(snp_addr))); // R5

    AST_ACK_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_kind |-> (rsp_data == '0)); // R5

    AST_RDINV_NO_WB: assert property (@(posedge clk) disable iff (rst)
        foreign && (snp_op == 2'd2) |=> !wb_valid && rsp_valid); // R6

    AST_OWN_DROPPED: assert property (@(posedge clk) disable iff (rst)
        snp_valid && snp_ready && (snp_src == MY_ID) |=> snp_ready && !rsp_valid && !wb_valid); // R8

    AST_BUSY_CLOSED: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !snp_ready); // R12

endmodule

bind mesi_snoop_unit snp_checker #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W),
    .ID_W   (ID_W),
    .MY_ID  (MY_ID)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .snp_valid (snp_valid),
    .snp_ready (snp_ready),
    .snp_op    (snp_op),
    .snp_src   (snp_src),
    .snp_addr  (snp_addr),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_addr   (wb_addr),
    .wb_data   (wb_data),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_kind  (rsp_kind),
    .rsp_dst   (rsp_dst),
    .rsp_addr  (rsp_addr),
    .rsp_data  (rsp_data)
);

// File: tb/test_mesi_snoop_unit.sv
module test_mesi_snoop_unit;

    localparam int ADDR_W = 16;
    localparam int LINE_W = 64;
    localparam int SETS   = 8;
    localparam int ID_W   = 2;
    localparam logic [ID_W-1:0] MY_ID = 1;
    localparam int OFF_W  = $clog2(LINE_W / 8);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    snp_valid = 1'b0;
    logic                    snp_ready;
    logic [1:0]              snp_op = '0;
    logic [ID_W-1:0]         snp_src = '0;
    logic [ADDR_W-1:0]       snp_addr = '0;
    logic                    fill_en = 1'b0;
    logic [ADDR_W-OFF_W-1:0] fill_line = '0;
    logic [1:0]              fill_st = '0;
    logic [LINE_W-1:0]       fill_data = '0;
    logic                    wb_valid;
    logic                    wb_ready = 1'b1;
    logic [ADDR_W-1:0]       wb_addr;
    logic [LINE_W-1:0]       wb_data;
    logic                    rsp_valid;
    logic                    rsp_ready = 1'b1;
    logic                    rsp_kind;
    logic [ID_W-1:0]         rsp_dst;
    logic [ADDR_W-1:0]       rsp_addr;
    logic [LINE_W-1:0]       rsp_data;

    always #4 clk = ~clk;

    mesi_snoop_unit #(
        .ADDR_W (ADDR_W), .LINE_W (LINE_W), .SETS (SETS), .ID_W (ID_W), .MY_ID (MY_ID)
    ) i_mesi_snoop_unit (
        .clk (clk), .rst (rst),
        .snp_valid (snp_valid), .snp_ready (snp_ready), .snp_op (snp_op),
        .snp_src (snp_src), .snp_addr (snp_addr),
        .fill_en (fill_en), .fill_line (fill_line), .fill_st (fill_st), .fill_data (fill_data),
        .wb_valid (wb_valid), .wb_ready (wb_ready), .wb_addr (wb_addr), .wb_data (wb_data),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_kind (rsp_kind),
        .rsp_dst (rsp_dst), .rsp_addr (rsp_addr), .rsp_data (rsp_data)
    );

    typedef struct {
        logic              kind;
        logic [ID_W-1:0]   dst;
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
    } exp_rsp_t;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [LINE_W-1:0] data;
    } exp_wb_t;

    exp_rsp_t rq[$];
    exp_wb_t  wq[$];

    // reference model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
    int                m_st   [SETS];
    logic [TAG_W-1:0]  m_tag  [SETS];
    logic [LINE_W-1:0] m_data [SETS];

    int    nchk = 0;
    int    nfail = 0;
    int    cyc = 0;
    bit    running = 1'b0;
    bit    stall_en = 1'b0;
    string cur_req = "R1";
    logic [15:0] lfsr = 16'hACE1;

    bit                held_r = 1'b0;
    exp_rsp_t          snap_r;
    bit                held_w = 1'b0;
    logic [ADDR_W-1:0] snap_wa;
    logic [LINE_W-1:0] snap_wd;

    function automatic void check(bit ok, string req, string msg);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s", req, msg);
        end
    endfunction

    function automatic logic [ADDR_W-1:0] mk(int tg, int ix, int of);
        return {TAG_W'(tg), IDX_W'(ix), OFF_W'(of)};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            summary();
        end
    end

    // per-cycle monitor: hold checks, handshake compares, spurious outputs
    always @(negedge clk) begin
        if (running) begin
            if (held_r)
                check(rsp_valid && rsp_kind == snap_r.kind && rsp_dst == snap_r.dst &&
                      rsp_addr == snap_r.addr && rsp_data == snap_r.data, "R9",
                      $sformatf("reply changed under stall: actual v%0b k%0b a%h, expected v1 k%0b a%h",
                                rsp_valid, rsp_kind, rsp_addr, snap_r.kind, snap_r.addr));
            if (held_w)
                check(wb_valid && wb_addr == snap_wa && wb_data == snap_wd, "R9",
                      $sformatf("write-back changed under stall: actual v%0b a%h, expected v1 a%h",
                                wb_valid, wb_addr, snap_wa));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rsp_ready = stall_en ? lfsr[0] : 1'b1;
            wb_ready  = stall_en ? lfsr[3] : 1'b1;
            held_r = rsp_valid && !rsp_ready;
            held_w = wb_valid && !wb_ready;
            snap_r.kind = rsp_kind; snap_r.dst = rsp_dst;
            snap_r.addr = rsp_addr; snap_r.data = rsp_data;
            snap_wa = wb_addr; snap_wd = wb_data;
            if (rsp_valid && rq.size() == 0)
                check(1'b0, "R12", $sformatf("unexpected reply: actual kind %0b addr %h, expected none",
                                             rsp_kind, rsp_addr));
            if (wb_valid && wq.size() == 0)
                check(1'b0, "R12", $sformatf("unexpected write-back: actual addr %h, expected none", wb_addr));
            if (wb_valid && wb_ready && wq.size() != 0) begin
                exp_wb_t e;
                e = wq.pop_front();
                check(wb_addr == e.addr && wb_data == e.data, "R3",
                      $sformatf("%s write-back: actual a%h d%h, expected a%h d%h",
                                cur_req, wb_addr, wb_data, e.addr, e.data));
            end
            if (rsp_valid && rsp_ready && rq.size() != 0) begin
                exp_rsp_t e;
                check(wq.size() == 0, "R3",
                      $sformatf("reply before write-back: actual %0d write-backs pending, expected 0", wq.size()));
                e = rq.pop_front();
                check(rsp_kind == e.kind && rsp_dst == e.dst && rsp_addr == e.addr && rsp_data == e.data,
                      cur_req, $sformatf("reply: actual k%0b dst%0d a%h d%h, expected k%0b dst%0d a%h d%h",
                                         rsp_kind, rsp_dst, rsp_addr, rsp_data,
                                         e.kind, e.dst, e.addr, e.data));
            end
        end
    end

    task automatic do_fill(int tg, int ix, int st, logic [LINE_W-1:0] d);
        @(negedge clk);
        fill_en = 1'b1;
        fill_line = {TAG_W'(tg), IDX_W'(ix)};
        fill_st = 2'(st);
        fill_data = d;
        m_st[ix] = st; m_tag[ix] = TAG_W'(tg); m_data[ix] = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_snoop(int op, int src, logic [ADDR_W-1:0] a, string req);
        int  ix;
        bit  hit;
        bit  quiet;
        exp_rsp_t r;
        ix = int'(a[OFF_W +: IDX_W]);
        @(negedge clk);
        while (!snp_ready) @(negedge clk);
        cur_req = req;
        snp_valid = 1'b1; snp_op = 2'(op); snp_src = ID_W'(src); snp_addr = a;
        hit = (m_st[ix] != 0) && (m_tag[ix] == a[ADDR_W-1 -: TAG_W]);
        quiet = 1'b1;
        r.dst = ID_W'(src); r.addr = a;
        if (ID_W'(src) != MY_ID && op != 3) begin
            if (op == 0 && hit) begin
                if (m_st[ix] == 3) wq.push_back('{addr: {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}, data: m_data[ix]});
                r.kind = 1'b0; r.data = m_data[ix]; rq.push_back(r);
                m_st[ix] = 1; quiet = 1'b0;
            end else if (op == 1 || op == 2) begin
                if (op == 2 && hit) begin
                    r.kind = 1'b0; r.data = m_data[ix]; rq.push_back(r);
                end
                if (hit) m_st[ix] = 0;
                r.kind = 1'b1; r.data = '0; rq.push_back(r);
                quiet = 1'b0;
            end
        end
        @(negedge clk);
        snp_valid = 1'b0;
        if (quiet)
            check(snp_ready && !rsp_valid && !wb_valid, req,
                  $sformatf("dropped request: actual rdy%0b rv%0b wv%0b, expected 1 0 0",
                            snp_ready, rsp_valid, wb_valid));
        else
            check(!snp_ready, "R12", $sformatf("busy after accept: actual rdy %0b, expected 0", snp_ready));
    endtask

    task automatic drain();
        @(negedge clk);
        while (rq.size() != 0 || wq.size() != 0 || !snp_ready) @(negedge clk);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_st[s] = 0; m_tag[s] = '0; m_data[s] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(snp_ready && !rsp_valid && !wb_valid, "R1",
              $sformatf("after reset: actual rdy%0b rv%0b wv%0b, expected 1 0 0", snp_ready, rsp_valid, wb_valid));
        running = 1'b1;

        do_snoop(0, 0, mk(0, 0, 0), "R1");            // all sets Invalid
        do_snoop(0, 2, mk(5, 3, 1), "R1");
        do_fill(17, 1, 2, 64'h1111_2222_3333_4444);   // Exclusive
        do_fill(9, 2, 1, 64'h5555_6666_7777_8888);    // Shared
        do_fill(40, 3, 3, 64'hDEAD_BEEF_0BAD_F00D);   // Modified
        do_fill(41, 4, 3, 64'hCAFE_0000_1234_5678);   // Modified
        do_snoop(0, 2, mk(17, 1, 5), "R2");
        do_snoop(0, 3, mk(9, 2, 0), "R2");
        do_snoop(0, 0, mk(40, 3, 7), "R3");
        drain();
        do_snoop(0, 2, mk(40, 3, 2), "R3");           // now Shared: no write-back
        do_snoop(0, 0, mk(10, 2, 0), "R10");          // same set, other tag
        do_snoop(0, 0, mk(3, 6, 0), "R4");
        do_snoop(1, 3, mk(17, 1, 0), "R5");
        drain();
        do_snoop(0, 2, mk(17, 1, 0), "R5");           // invalidated: silent
        do_snoop(1, 0, mk(2, 5, 4), "R5");            // miss still acked
        do_snoop(2, 2, mk(41, 4, 1), "R6");           // Modified: data then ack
        drain();
        do_snoop(0, 0, mk(41, 4, 1), "R6");
        do_snoop(2, 3, mk(8, 7, 0), "R7");
        do_fill(22, 6, 3, 64'h0F0F_0F0F_A5A5_5A5A);
        do_snoop(0, 1, mk(22, 6, 0), "R8");
        do_snoop(1, 1, mk(22, 6, 0), "R8");
        do_snoop(2, 1, mk(22, 6, 0), "R8");
        do_snoop(3, 0, mk(22, 6, 0), "R8");
        do_snoop(0, 0, mk(22, 6, 3), "R8");           // still Modified
        drain();
        do_fill(30, 0, 2, 64'h0123_4567_89AB_CDEF);
        do_snoop(0, 2, mk(30, 0, 6), "R11");
        drain();

        stall_en = 1'b1;
        do_fill(12, 7, 3, 64'h7777_0000_7777_0000);
        do_snoop(0, 3, mk(12, 7, 0), "R9");
        drain();
        for (int n = 0; n < 400; n++) begin
            int sel;
            sel = int'($urandom % 3);
            if (sel == 0)
                do_fill(int'($urandom % 2), int'($urandom % SETS), int'($urandom % 4),
                        {$urandom, $urandom});
            else
                do_snoop(int'($urandom % 4), int'($urandom % 4),
                         mk(int'($urandom % 2), int'($urandom % SETS), int'($urandom % 8)), "R2");
        end
        drain();
        repeat (4) @(negedge clk);
        check(rq.size() == 0 && wq.size() == 0 && snp_ready, "R12",
              $sformatf("end: actual %0d replies %0d write-backs pending, expected 0 0", rq.size(), wq.size()));
        running = 1'b0;
        summary();
    end

endmodule